// File: doc/BRIEF.md
# Synchronous Burst Read Port

This block is the memory side of a synchronous, NOR-style burst read interface. The host drives an address and pulses an active-low address strobe while chip select is low. The block then counts a programmable number of wait cycles. After that it streams words from linearly increasing addresses, one word per active clock edge, for as long as chip select stays low. A ready output tells the host which cycles carry valid data.

The block reads from an internal 1024-word read-only array. Each word holds its own address XORed with a fixed pattern, so every returned value can be predicted. When a burst moves onto an address that is a multiple of 64, the block holds ready low for a few stall cycles before it presents that word. The number of stall cycles depends on the configured latency. A configuration bit makes either the rising or the falling clock edge the active edge.

Top module: `sync_burst_rd`

## Requirements
- R1: A latency setting `cfg_latency` of 0 or 1 behaves exactly like a setting of 2. Settings 2 to 7 are used as given.
- R2: With `cfg_fall_edge`=1, all sampling and all output updates happen on falling clock edges. With 0 they happen on rising edges.
- R3: An active edge with `ce_n`=0 and `adv_n`=0 captures `addr`. After the capture edge, `rdy` is 0 for the next L-1 active edges, where L is the effective latency. The L-th active edge makes `rdy` 1 and presents the word at the captured address.
- R4: While `ce_n` stays 0 and `adv_n` stays 1, each further active edge presents the word at the next address. Every word equals its 10-bit address, zero-extended, XOR 16'hA5C3.
- R5: When the next address is a multiple of 64, and the effective latency is 5 or less, `rdy` is 0 for exactly 2 active edges before that word appears. The wrap from address 1023 to address 0 counts as such a crossing.
- R6: When the effective latency is 6 or 7, the boundary crossing of R5 inserts exactly 3 stall edges instead of 2.
- R7: `dq_oe` is 1 only when both `ce_n` and `oe_n` are 0. In every other case it is 0, so the data lines are floating.
- R8: An active edge with `ce_n`=1 ends the burst. `rdy` is 0 after that edge and stays 0 until a new capture completes its latency.
- R9: A new capture during a burst abandons that burst and restarts the latency count from the new address.
- R10: After synchronous reset, `rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the active edge |
| cfg_fall_edge | input | 1 | 1 selects the falling edge as the active edge |
| cfg_latency | input | 3 | Initial latency in cycles, clamped to at least 2 |
| ce_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Burst start address |
| dq | output | 16 | Read data |
| dq_oe | output | 1 | Drive enable for the data lines |
| rdy | output | 1 | High on cycles that carry a valid word |

## Verification
The bench builds the block with its default parameters: a 10-bit address, a 64-word stall segment and the 16'hA5C3 fill pattern. The array is small enough that short bursts starting just below 64, 128, 192 and the top of the array reach each boundary kind, including the wrap to address 0. The bench runs these bursts at latencies on both sides of the 2-stall/3-stall split. It also covers the falling-edge mode. In that mode one sample is taken just after a rising edge, which would expose an update on the wrong edge.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int LAT_W   = 3;
  localparam int STALL_W = 2;

  // Effective initial latency: settings below the minimum become the minimum.
  function automatic logic [LAT_W-1:0] eff_latency(input logic [LAT_W-1:0] raw);
    return (raw < LAT_W'(2)) ? LAT_W'(2) : raw;
  endfunction

  // Stall cycles inserted when a burst enters a new segment.
  function automatic logic [STALL_W-1:0] seg_stall(input logic [LAT_W-1:0] lat);
    return (lat >= LAT_W'(6)) ? STALL_W'(3) : STALL_W'(2);
  endfunction
endpackage

// File: rtl/sbr_cfg.sv
module sbr_cfg
  import sbr_pkg::*;
(
  input  logic [LAT_W-1:0]   raw_lat,
  output logic [LAT_W-1:0]   lat,
  output logic [STALL_W-1:0] stall
);
  always_comb begin
    lat   = eff_latency(raw_lat);
    stall = seg_stall(lat);
  end
endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
  parameter int          AW      = 10,
  parameter int          DW      = 16,
  parameter logic [15:0] PATTERN = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i) ^ DW'(PATTERN);
  end

  // Registered read, no reset on the data path: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int AW    = 10,
  parameter int SEG_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_n,
  input  logic               adv_n,
  input  logic [AW-1:0]      addr,
  input  logic [LAT_W-1:0]   lat,
  input  logic [STALL_W-1:0] stall,
  output logic               rd_en,
  output logic [AW-1:0]      rd_addr,
  output logic               rdy
);
  logic               active;
  logic [LAT_W-1:0]   wcnt;
  logic [LAT_W-1:0]   lat_q;
  logic [STALL_W-1:0] stall_q;
  logic [AW-1:0]      ptr;
  logic [AW-1:0]      ptr_nxt;
  logic               capture;

  assign capture = ~ce_n & ~adv_n;
  assign ptr_nxt = ptr + AW'(1);
  assign rd_en   = ~ce_n & adv_n & active & (wcnt == '0);
  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      wcnt    <= '0;
      lat_q   <= LAT_W'(2);
      stall_q <= STALL_W'(2);
      ptr     <= '0;
      rdy     <= 1'b0;
    end else if (ce_n) begin
      active <= 1'b0;
      rdy    <= 1'b0;
    end else if (capture) begin
      active  <= 1'b1;
      ptr     <= addr;
      wcnt    <= lat - LAT_W'(1);
      lat_q   <= lat;
      stall_q <= stall;
      rdy     <= 1'b0;
    end else if (active) begin
      if (wcnt != '0) begin
        wcnt <= wcnt - LAT_W'(1);
        rdy  <= 1'b0;
      end else begin
        rdy <= 1'b1;
        ptr <= ptr_nxt;
        if (ptr_nxt[SEG_W-1:0] == '0) wcnt <= LAT_W'(stall_q);
      end
    end
  end

  a_r3_capture_rdy_low: assert property (@(posedge clk) disable iff (rst)
    capture |=> !rdy);
  a_r8_abort_rdy_low: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !rdy);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + AW'(1))));
  a_r5_boundary_stall: assert property (@(posedge clk) disable iff (rst)
    (rdy && (ptr[SEG_W-1:0] == '0)) |=> !rdy);
  a_r1_lat_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (lat_q >= LAT_W'(2)));
endmodule

// File: rtl/sync_burst_rd.sv
module sync_burst_rd
  import sbr_pkg::*;
#(
  parameter int          AW      = 10,
  parameter int          DW      = 16,
  parameter int          SEG_W   = 6,
  parameter logic [15:0] PATTERN = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_fall_edge,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  output logic [DW-1:0]    dq,
  output logic             dq_oe,
  output logic             rdy
);
  logic               act_clk;
  logic [LAT_W-1:0]   lat;
  logic [STALL_W-1:0] stall;
  logic               rd_en;
  logic [AW-1:0]      rd_addr;

  // Inverting the clock moves every register onto the falling edge.
  assign act_clk = clk ^ cfg_fall_edge;
  assign dq_oe   = ~ce_n & ~oe_n;

  sbr_cfg u_cfg (
    .raw_lat (cfg_latency),
    .lat     (lat),
    .stall   (stall)
  );

  sbr_seq #(.AW(AW), .SEG_W(SEG_W)) u_seq (
    .clk     (act_clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .adv_n   (adv_n),
    .addr    (addr),
    .lat     (lat),
    .stall   (stall),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rdy     (rdy)
  );

  sbr_array #(.AW(AW), .DW(DW), .PATTERN(PATTERN)) u_array (
    .clk     (act_clk),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (dq)
  );
endmodule

// File: tb/sync_burst_rd_test.sv
module sync_burst_rd_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [15:0] PAT = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fall = 1'b0;
  logic [2:0]  lat = 3'd4;
  logic        ce_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] dq;
  logic        dq_oe;
  logic        rdy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sync_burst_rd uut (
    .clk(clk), .rst(rst), .cfg_fall_edge(fall), .cfg_latency(lat),
    .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n), .addr(addr),
    .dq(dq), .dq_oe(dq_oe), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic act_edge();
    if (fall) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; ce_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1;
    repeat (3) act_edge();
    rst = 1'b0;
    act_edge();
  endtask

  task automatic start(input logic [9:0] a, input logic [2:0] l);
    lat = l; addr = a; ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0;
    act_edge();
    adv_n = 1'b1;
  endtask

  task automatic stop_burst();
    ce_n = 1'b1;
    act_edge();
  endtask

  // Expected stream from the requirements: L-1 quiet edges, then one word
  // per edge, with 2 or 3 quiet edges before each 64-aligned address.
  task automatic follow(input logic [9:0] a, input logic [2:0] l, input int n,
                        input string req);
    int          eff;
    int          st;
    int          wt;
    logic [9:0]  ea;
    eff = (l < 3'd2) ? 2 : int'(l);
    st  = (eff >= 6) ? 3 : 2;
    wt  = eff - 1;
    ea  = a;
    for (int e = 0; e < n; e++) begin
      act_edge();
      if (wt != 0) begin
        chk(rdy == 1'b0, req, "rdy in wait", int'(rdy), 0);
        wt--;
      end else begin
        chk(rdy == 1'b1, req, "rdy on data", int'(rdy), 1);
        chk(dq == ({6'd0, ea} ^ PAT), req, "data word", int'(dq), int'({6'd0, ea} ^ PAT));
        ea = ea + 10'd1;
        if (ea[5:0] == 6'd0) wt = st;
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(rdy == 1'b0, "R10", "rdy after reset", int'(rdy), 0);
    chk(dq_oe == 1'b0, "R7", "dq_oe idle", int'(dq_oe), 0);
  endtask

  task automatic t_oe();
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk(dq_oe == 1'b0, "R7", "oe_n high", int'(dq_oe), 0);
    oe_n = 1'b0; #1;
    chk(dq_oe == 1'b1, "R7", "both low", int'(dq_oe), 1);
    ce_n = 1'b1; #1;
    chk(dq_oe == 1'b0, "R7", "ce_n high", int'(dq_oe), 0);
    act_edge();
  endtask

  task automatic t_latency();
    start(10'd100, 3'd2); follow(10'd100, 3'd2, 9,  "R3 R4"); stop_burst();
    start(10'd100, 3'd4); follow(10'd100, 3'd4, 11, "R3 R4"); stop_burst();
    start(10'd100, 3'd7); follow(10'd100, 3'd7, 14, "R3 R4"); stop_burst();
  endtask

  task automatic t_clamp();
    start(10'd40, 3'd0); follow(10'd40, 3'd0, 6, "R1"); stop_burst();
    start(10'd41, 3'd1); follow(10'd41, 3'd1, 6, "R1"); stop_burst();
  endtask

  task automatic t_boundary();
    start(10'd61,   3'd3); follow(10'd61,   3'd3, 10, "R5"); stop_burst();
    start(10'd125,  3'd5); follow(10'd125,  3'd5, 12, "R5"); stop_burst();
    start(10'd190,  3'd6); follow(10'd190,  3'd6, 13, "R6"); stop_burst();
    start(10'd1021, 3'd7); follow(10'd1021, 3'd7, 16, "R6"); stop_burst();
  endtask

  task automatic t_abort();
    start(10'd500, 3'd3);
    follow(10'd500, 3'd3, 6, "R8");
    ce_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      act_edge();
      chk(rdy == 1'b0, "R8", "rdy after abort", int'(rdy), 0);
    end
    chk(dq_oe == 1'b0, "R8", "dq_oe after abort", int'(dq_oe), 0);
  endtask

  task automatic t_restart();
    start(10'd700, 3'd4);
    follow(10'd700, 3'd4, 6, "R9");
    addr = 10'd900; adv_n = 1'b0;
    act_edge();
    adv_n = 1'b1;
    chk(rdy == 1'b0, "R9", "rdy on restart", int'(rdy), 0);
    follow(10'd900, 3'd4, 8, "R9");
    stop_burst();
  endtask

  task automatic t_fall();
    fall = 1'b1;
    do_reset();
    start(10'd300, 3'd4);
    follow(10'd300, 3'd4, 3, "R2");
    @(posedge clk); #1;
    chk(rdy == 1'b0, "R2", "rdy after rising edge", int'(rdy), 0);
    act_edge();
    chk(rdy == 1'b1, "R2", "rdy on falling edge", int'(rdy), 1);
    chk(dq == (16'd300 ^ PAT), "R2", "first word", int'(dq), int'(16'd300 ^ PAT));
    act_edge();
    chk(dq == (16'd301 ^ PAT), "R2", "second word", int'(dq), int'(16'd301 ^ PAT));
    stop_burst();
    fall = 1'b0;
    do_reset();
  endtask

  initial begin
    t_reset();
    t_oe();
    t_latency();
    t_clamp();
    t_boundary();
    t_abort();
    t_restart();
    t_fall();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule